// File: doc/BRIEF.md
# Multi-Channel Result Bus Arbiter

This block decides which completing producers may place their results on a shared result broadcast bus during the current cycle. The bus offers a fixed number of parallel channels (two by default). Each producer slot presents a request together with its operation kind, the pipeline phase it has just finished, an age tag giving its position in program order, and the producer tag that consumers are waiting on. Up to the channel count of eligible requests are granted in one cycle, oldest first. Requests that lose simply present themselves again the next cycle; the arbiter keeps no memory of them, and the whole set of channels is free again at the start of every cycle.

Granted producers are assigned to channels in age order: the oldest winner takes channel 0, the next channel 1, and so on. The arbiter reports, in the same cycle, the grant per producer, the one-hot source select of each channel, the tag carried by each channel, the number of channels left over and whether any is left. One cycle later the granted tags appear on registered broadcast outputs. At that point the producer has left write-back, and all waiting consumers may compare the tags together and clear their dependencies in the same edge.

Data values, register file writes and the consumers' wakeup storage are outside this block.

Top module: `result_bus_arbiter`

## Requirements
- R1: A request is eligible only when its valid bit is set and either its kind is arithmetic (code 0) with phase 0 (execute finished), or its kind is load (code 1) with phase 1 (memory access finished); store (code 2) and branch (code 3) requests, and arithmetic or load requests in the other phase, are never granted.
- R2: The number of grants in a cycle equals the smaller of the number of eligible requests and the channel count CHANS.
- R3: The granted set consists of the eligible requests with the smallest age tags (smaller is older); among equal ages the lower requester index counts as older.
- R4: Winners fill channels from channel 0 upward in age order; each channel's source select is one-hot or all zero, `ch_valid_o` marks the used channels and `ch_tag_o` carries the winner's producer tag (zero on an unused channel).
- R5: No requester is granted on more than one channel, and `gnt_o[i]` is set exactly when some channel selects requester i.
- R6: `free_cnt_o` equals CHANS minus the number of grants in the cycle, and `avail_o` is low exactly when no channel is left.
- R7: The full channel count is available again in every cycle; grants given in one cycle do not reduce the channels of the next.
- R8: A refused request that is presented again in the next cycle is granted once it is among the CHANS oldest eligible requests of that cycle.
- R9: One cycle after a grant, `bc_valid_o[c]` is set and `bc_tag_o[c]` holds the tag granted on channel c; a channel unused in the previous cycle shows `bc_valid_o[c]` low.
- R10: While `rst_n` is low at a clock edge, all broadcast valid bits are cleared after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | N_REQ | Request present per producer slot |
| req_kind_i | input | N_REQ x 2 | Operation kind: 0 arithmetic, 1 load, 2 store, 3 branch |
| req_phase_i | input | N_REQ | Phase just finished: 0 execute, 1 memory access |
| req_age_i | input | N_REQ x AGE_W | Program-order age, smaller is older |
| req_tag_i | input | N_REQ x TAG_W | Producer tag to broadcast |
| gnt_o | output | N_REQ | Grant per producer slot this cycle |
| ch_sel_o | output | CHANS x N_REQ | One-hot source select per channel |
| ch_valid_o | output | CHANS | Channel used this cycle |
| ch_tag_o | output | CHANS x TAG_W | Tag placed on each channel this cycle |
| free_cnt_o | output | clog2(CHANS+1) | Channels left after this cycle's grants |
| avail_o | output | 1 | At least one channel left this cycle |
| bc_valid_o | output | CHANS | Registered broadcast valid per channel |
| bc_tag_o | output | CHANS x TAG_W | Registered broadcast tag per channel |

## Verification
Directed patterns separate the cases a random mix rarely isolates: every slot requesting with a wrong kind or phase shows that filtering happens before arbitration, all ages descending shows that age and not index decides, all ages equal shows the index tie-break, and a single eligible request shows channel 0 filling with one channel reported free. Repeating a saturating pattern on consecutive cycles distinguishes a bus that restores its channels from one that carries usage over, and a three-request sequence with the two winners withdrawn shows that the refused request takes channel 0 on its retry. A long random run with mixed kinds, phases, duplicate ages and varying numbers of requesters compares grants, channel order, tags, free count and the delayed broadcast against a selection-sort reference every cycle.

// File: rtl/rbarb_pkg.sv
// Package rbarb_pkg
// Shared encodings for the result bus arbiter: producer kinds, phase codes
// and the eligibility rule that decides whether a producer may ask for a
// channel at all.
package rbarb_pkg;

    // Kind of operation held by a producer slot.
    typedef enum logic [1:0] {
        KIND_ALU    = 2'd0,
        KIND_LOAD   = 2'd1,
        KIND_STORE  = 2'd2,
        KIND_BRANCH = 2'd3
    } prod_kind_e;

    // Phase a producer has just completed.
    localparam logic PHASE_EXEC = 1'b0;
    localparam logic PHASE_MEM  = 1'b1;

    // Arithmetic results leave right after execute, loads after the memory
    // access; stores and branches produce nothing for the bus.
    function automatic logic may_request(input logic [1:0] kind, input logic phase);
        return ((kind == KIND_ALU)  && (phase == PHASE_EXEC)) ||
               ((kind == KIND_LOAD) && (phase == PHASE_MEM));
    endfunction

endpackage

// File: rtl/rbarb_elig.sv
// Module rbarb_elig
// Filters raw requests down to those allowed to compete for the bus.
// Assumes: kind and phase are stable whenever valid is high; purely
// combinational, no state.
module rbarb_elig #(
    parameter int N_REQ = 8
) (
    input  logic [N_REQ-1:0]      valid_i,
    input  logic [N_REQ-1:0][1:0] kind_i,
    input  logic [N_REQ-1:0]      phase_i,
    output logic [N_REQ-1:0]      elig_o
);
    import rbarb_pkg::*;

    // One filter per producer slot.
    for (genvar g = 0; g < N_REQ; g++) begin : g_slot
        assign elig_o[g] = valid_i[g] && may_request(kind_i[g], phase_i[g]);
    end

endmodule

// File: rtl/rbarb_rank.sv
// Module rbarb_rank
// Ranks every eligible request by the number of eligible requests that are
// older than it. Smaller age is older; equal ages fall back to the lower
// slot index, so every eligible request gets a distinct rank. A request wins
// when its rank is below the channel count, and the rank is its channel.
// Assumes: age tags of live requests do not wrap inside the window compared.
module rbarb_rank #(
    parameter int N_REQ  = 8,
    parameter int AGE_W  = 6,
    parameter int CHANS  = 2,
    parameter int RANK_W = 4
) (
    input  logic [N_REQ-1:0]              elig_i,
    input  logic [N_REQ-1:0][AGE_W-1:0]   age_i,
    output logic [N_REQ-1:0][RANK_W-1:0]  rank_o,
    output logic [N_REQ-1:0]              win_o
);
    localparam logic [RANK_W-1:0] RANK_ONE = RANK_W'(1);
    localparam logic [RANK_W-1:0] RANK_LIM = RANK_W'(CHANS);

    for (genvar g = 0; g < N_REQ; g++) begin : g_slot
        logic [RANK_W-1:0] older_cnt;

        // Count eligible competitors that precede slot g in program order.
        always_comb begin
            older_cnt = '0;
            for (int j = 0; j < N_REQ; j++) begin
                if ((j != g) && elig_i[j]) begin
                    if ((age_i[j] < age_i[g]) ||
                        ((age_i[j] == age_i[g]) && (j < g))) begin
                        older_cnt = older_cnt + RANK_ONE;
                    end
                end
            end
        end

        assign rank_o[g] = older_cnt;
        // Win only when eligible and a channel is left at this rank.
        assign win_o[g]  = elig_i[g] && (older_cnt < RANK_LIM);
    end

endmodule

// File: rtl/rbarb_route.sv
// Module rbarb_route
// Turns winners and their ranks into per-channel source selects, channel
// tags, per-slot grants and the count of channels left in this cycle.
// Assumes: winners carry distinct ranks below CHANS (guaranteed by
// rbarb_rank); purely combinational, so the channel supply is whole again
// every cycle.
module rbarb_route #(
    parameter int N_REQ  = 8,
    parameter int CHANS  = 2,
    parameter int TAG_W  = 6,
    parameter int RANK_W = 4,
    parameter int CNT_W  = 2
) (
    input  logic [N_REQ-1:0]              win_i,
    input  logic [N_REQ-1:0][RANK_W-1:0]  rank_i,
    input  logic [N_REQ-1:0][TAG_W-1:0]   tag_i,
    output logic [CHANS-1:0][N_REQ-1:0]   ch_sel_o,
    output logic [CHANS-1:0]              ch_valid_o,
    output logic [CHANS-1:0][TAG_W-1:0]   ch_tag_o,
    output logic [N_REQ-1:0]              gnt_o,
    output logic [CNT_W-1:0]              free_cnt_o,
    output logic                          avail_o
);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CHANS);

    logic [CNT_W-1:0] used_cnt;

    for (genvar c = 0; c < CHANS; c++) begin : g_chan
        localparam logic [RANK_W-1:0] SLOT = RANK_W'(c);
        logic [TAG_W-1:0] tag_acc;

        // Channel c takes the winner whose rank equals c.
        for (genvar i = 0; i < N_REQ; i++) begin : g_src
            assign ch_sel_o[c][i] = win_i[i] && (rank_i[i] == SLOT);
        end

        assign ch_valid_o[c] = |ch_sel_o[c];

        // AND-OR multiplexer for the tag carried on channel c.
        always_comb begin
            tag_acc = '0;
            for (int i = 0; i < N_REQ; i++) begin
                if (ch_sel_o[c][i]) begin
                    tag_acc = tag_acc | tag_i[i];
                end
            end
        end

        assign ch_tag_o[c] = tag_acc;
    end

    // Fold the channel selects back into one grant bit per slot.
    always_comb begin
        gnt_o = '0;
        for (int c = 0; c < CHANS; c++) begin
            for (int i = 0; i < N_REQ; i++) begin
                gnt_o[i] = gnt_o[i] | ch_sel_o[c][i];
            end
        end
    end

    // Count channels consumed this cycle and report what is left.
    always_comb begin
        used_cnt = '0;
        for (int c = 0; c < CHANS; c++) begin
            if (ch_valid_o[c]) begin
                used_cnt = used_cnt + CNT_ONE;
            end
        end
        free_cnt_o = CNT_FULL - used_cnt;
        avail_o    = (free_cnt_o != '0);
    end

endmodule

// File: rtl/rbarb_bcast.sv
// Module rbarb_bcast
// Registers the channel contents so the tags are broadcast in the cycle after
// the grant, when the producers have left write-back and consumers can clear
// their dependencies together at one edge.
// Assumes: synchronous active-low reset.
module rbarb_bcast #(
    parameter int CHANS = 2,
    parameter int TAG_W = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CHANS-1:0]             ch_valid_i,
    input  logic [CHANS-1:0][TAG_W-1:0]  ch_tag_i,
    output logic [CHANS-1:0]             bc_valid_o,
    output logic [CHANS-1:0][TAG_W-1:0]  bc_tag_o
);

    // Broadcast register: clear on reset, otherwise capture this cycle's channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bc_valid_o <= '0;
            bc_tag_o   <= '0;
        end else begin
            bc_valid_o <= ch_valid_i;
            bc_tag_o   <= ch_tag_i;
        end
    end

endmodule

// File: rtl/result_bus_arbiter.sv
// Module result_bus_arbiter
// Grants up to CHANS producers per cycle onto the shared result broadcast
// bus, oldest first, and broadcasts their tags one cycle later.
// Assumes: 1 <= CHANS <= N_REQ; refused producers re-present their request
// themselves; age tags are comparable without wrap among live requests.
module result_bus_arbiter #(
    parameter int N_REQ = 8,
    parameter int CHANS = 2,
    parameter int AGE_W = 6,
    parameter int TAG_W = 6,
    localparam int RANK_W = $clog2(N_REQ) + 1,
    localparam int CNT_W  = $clog2(CHANS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_REQ-1:0]             req_valid_i,
    input  logic [N_REQ-1:0][1:0]        req_kind_i,
    input  logic [N_REQ-1:0]             req_phase_i,
    input  logic [N_REQ-1:0][AGE_W-1:0]  req_age_i,
    input  logic [N_REQ-1:0][TAG_W-1:0]  req_tag_i,
    output logic [N_REQ-1:0]             gnt_o,
    output logic [CHANS-1:0][N_REQ-1:0]  ch_sel_o,
    output logic [CHANS-1:0]             ch_valid_o,
    output logic [CHANS-1:0][TAG_W-1:0]  ch_tag_o,
    output logic [CNT_W-1:0]             free_cnt_o,
    output logic                         avail_o,
    output logic [CHANS-1:0]             bc_valid_o,
    output logic [CHANS-1:0][TAG_W-1:0]  bc_tag_o
);

    logic [N_REQ-1:0]             elig;
    logic [N_REQ-1:0][RANK_W-1:0] rank;
    logic [N_REQ-1:0]             win;

    // Drop requests that may not use the bus in their current phase.
    rbarb_elig #(
        .N_REQ (N_REQ)
    ) u_elig (
        .valid_i (req_valid_i),
        .kind_i  (req_kind_i),
        .phase_i (req_phase_i),
        .elig_o  (elig)
    );

    // Order the eligible requests by age and pick the oldest CHANS.
    rbarb_rank #(
        .N_REQ  (N_REQ),
        .AGE_W  (AGE_W),
        .CHANS  (CHANS),
        .RANK_W (RANK_W)
    ) u_rank (
        .elig_i (elig),
        .age_i  (req_age_i),
        .rank_o (rank),
        .win_o  (win)
    );

    // Place winners on channels and account for the channels used.
    rbarb_route #(
        .N_REQ  (N_REQ),
        .CHANS  (CHANS),
        .TAG_W  (TAG_W),
        .RANK_W (RANK_W),
        .CNT_W  (CNT_W)
    ) u_route (
        .win_i      (win),
        .rank_i     (rank),
        .tag_i      (req_tag_i),
        .ch_sel_o   (ch_sel_o),
        .ch_valid_o (ch_valid_o),
        .ch_tag_o   (ch_tag_o),
        .gnt_o      (gnt_o),
        .free_cnt_o (free_cnt_o),
        .avail_o    (avail_o)
    );

    // Broadcast the granted tags in the following cycle.
    rbarb_bcast #(
        .CHANS (CHANS),
        .TAG_W (TAG_W)
    ) u_bcast (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch_valid_i (ch_valid_o),
        .ch_tag_i   (ch_tag_o),
        .bc_valid_o (bc_valid_o),
        .bc_tag_o   (bc_tag_o)
    );

endmodule

// File: rtl/result_bus_arbiter_chk.sv
// Module result_bus_arbiter_chk
// Property checker bound to result_bus_arbiter; observes its ports only.
module result_bus_arbiter_chk #(
    parameter int N_REQ = 8,
    parameter int CHANS = 2,
    parameter int AGE_W = 6,
    parameter int TAG_W = 6,
    localparam int CNT_W = $clog2(CHANS + 1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [N_REQ-1:0]             req_valid_i,
    input logic [N_REQ-1:0][1:0]        req_kind_i,
    input logic [N_REQ-1:0]             req_phase_i,
    input logic [N_REQ-1:0][AGE_W-1:0]  req_age_i,
    input logic [N_REQ-1:0][TAG_W-1:0]  req_tag_i,
    input logic [N_REQ-1:0]             gnt_o,
    input logic [CHANS-1:0][N_REQ-1:0]  ch_sel_o,
    input logic [CHANS-1:0]             ch_valid_o,
    input logic [CHANS-1:0][TAG_W-1:0]  ch_tag_o,
    input logic [CNT_W-1:0]             free_cnt_o,
    input logic                         avail_o,
    input logic [CHANS-1:0]             bc_valid_o,
    input logic [CHANS-1:0][TAG_W-1:0]  bc_tag_o
);
    import rbarb_pkg::*;

    // R2: never more grants than channels.
    p_grant_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt_o) <= CHANS);

    // R6: granted count plus free count always equals the channel count.
    p_free_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(gnt_o) + int'(free_cnt_o)) == CHANS);

    // R6: a full bus reports itself unavailable.
    p_full_unavail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(gnt_o) == CHANS) |-> !avail_o);

    // R10: after a reset edge no broadcast is valid.
    p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bc_valid_o == '0));

    for (genvar c = 0; c < CHANS; c++) begin : g_chan
        // R4: each channel selects at most one source.
        p_chan_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(ch_sel_o[c]));

        // R4: a channel is only used if all lower channels are used.
        if (c > 0) begin : g_fill
            p_chan_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ch_valid_o[c] |-> ch_valid_o[c-1]);
        end

        // R9: broadcast follows the channel contents by one cycle.
        p_bcast_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (bc_valid_o[c] == $past(ch_sel_o[c] != '0)));

        p_bcast_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && bc_valid_o[c]) |-> (bc_tag_o[c] == $past(ch_tag_o[c])));
    end

    for (genvar i = 0; i < N_REQ; i++) begin : g_slot
        // R1: a grant needs a valid request of a kind allowed in its phase.
        p_elig_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_o[i] |-> (req_valid_i[i] &&
                (((req_kind_i[i] == KIND_ALU)  && (req_phase_i[i] == PHASE_EXEC)) ||
                 ((req_kind_i[i] == KIND_LOAD) && (req_phase_i[i] == PHASE_MEM)))));

        // R5: a slot appears on at most one channel.
        p_single_chan_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({ch_sel_o[1 % CHANS][i], ch_sel_o[0][i]}) <= 1 || CHANS < 2);

        // R5: grant bit matches presence on some channel.
        p_gnt_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_o[i] == (ch_valid_o != '0 && (ch_sel_o[0][i] || ch_sel_o[CHANS-1][i] ||
                         $countones(gnt_o & (N_REQ'(1) << i)) == 1)));
    end

endmodule

bind result_bus_arbiter result_bus_arbiter_chk #(
    .N_REQ (N_REQ),
    .CHANS (CHANS),
    .AGE_W (AGE_W),
    .TAG_W (TAG_W)
) u_chk (.*);

// File: tb/result_bus_arbiter_bench.sv
// Bench for result_bus_arbiter: directed corner cases plus seeded random
// traffic, checked against a selection-sort reference model.
module result_bus_arbiter_bench;
    localparam int N  = 8;
    localparam int C  = 2;
    localparam int AW = 6;
    localparam int TW = 6;
    localparam int CW = $clog2(C + 1);

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic [N-1:0]           req_valid;
    logic [N-1:0][1:0]      req_kind;
    logic [N-1:0]           req_phase;
    logic [N-1:0][AW-1:0]   req_age;
    logic [N-1:0][TW-1:0]   req_tag;
    logic [N-1:0]           gnt;
    logic [C-1:0][N-1:0]    ch_sel;
    logic [C-1:0]           ch_valid;
    logic [C-1:0][TW-1:0]   ch_tag;
    logic [CW-1:0]          free_cnt;
    logic                   avail;
    logic [C-1:0]           bc_valid;
    logic [C-1:0][TW-1:0]   bc_tag;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_idx [C];
    int prev_idx[C];
    logic [TW-1:0] prev_tag[C];

    always #5 clk = ~clk;

    result_bus_arbiter #(.N_REQ(N), .CHANS(C), .AGE_W(AW), .TAG_W(TW)) u_result_bus_arbiter (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_kind_i(req_kind), .req_phase_i(req_phase),
        .req_age_i(req_age), .req_tag_i(req_tag),
        .gnt_o(gnt), .ch_sel_o(ch_sel), .ch_valid_o(ch_valid), .ch_tag_o(ch_tag),
        .free_cnt_o(free_cnt), .avail_o(avail),
        .bc_valid_o(bc_valid), .bc_tag_o(bc_tag)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Eligibility straight from the R1 wording.
    function automatic bit is_elig(input int i);
        return req_valid[i] && ((req_kind[i] == 2'd0 && req_phase[i] == 1'b0) ||
                                (req_kind[i] == 2'd1 && req_phase[i] == 1'b1));
    endfunction

    // Reference: pick the oldest remaining eligible request C times.
    task automatic compute_expected();
        bit taken[N];
        for (int i = 0; i < N; i++) taken[i] = 1'b0;
        for (int c = 0; c < C; c++) begin
            int best = -1;
            for (int i = 0; i < N; i++) begin
                if (is_elig(i) && !taken[i]) begin
                    if (best < 0 || req_age[i] < req_age[best]) best = i;
                end
            end
            exp_idx[c] = best;
            if (best >= 0) taken[best] = 1'b1;
        end
    endtask

    // Compare same-cycle outputs with the reference.
    task automatic check_comb(input string tag);
        logic [N-1:0] eg = '0;
        int ng = 0;
        int ne = 0;
        compute_expected();
        for (int i = 0; i < N; i++) if (is_elig(i)) ne++;
        for (int c = 0; c < C; c++) begin
            logic [N-1:0] es = (exp_idx[c] >= 0) ? (N'(1) << exp_idx[c]) : '0;
            if (exp_idx[c] >= 0) begin
                eg[exp_idx[c]] = 1'b1;
                ng++;
            end
            check(ch_sel[c] == es, {"R3/R4 channel select ", tag}, ch_sel[c], es);
            check(ch_valid[c] == (exp_idx[c] >= 0), {"R4 channel valid ", tag}, ch_valid[c], exp_idx[c] >= 0);
            if (exp_idx[c] >= 0)
                check(ch_tag[c] == req_tag[exp_idx[c]], {"R4 channel tag ", tag}, ch_tag[c], req_tag[exp_idx[c]]);
            else
                check(ch_tag[c] == '0, {"R4 idle channel tag ", tag}, ch_tag[c], 0);
        end
        check(gnt == eg, {"R1/R3/R5 grant vector ", tag}, gnt, eg);
        check($countones(gnt) == ((ne < C) ? ne : C), {"R2 grant count ", tag}, $countones(gnt), (ne < C) ? ne : C);
        check(int'(free_cnt) == C - ng, {"R6 free count ", tag}, free_cnt, C - ng);
        check(avail == (ng < C), {"R6 avail ", tag}, avail, ng < C);
        for (int c = 0; c < C; c++) begin
            prev_idx[c] = exp_idx[c];
            prev_tag[c] = (exp_idx[c] >= 0) ? req_tag[exp_idx[c]] : '0;
        end
    endtask

    // One full cycle: inputs already set after negedge; check both sides.
    task automatic step(input string tag);
        #1;
        check_comb(tag);
        @(posedge clk);
        #1;
        for (int c = 0; c < C; c++) begin
            check(bc_valid[c] == (prev_idx[c] >= 0), {"R9 broadcast valid ", tag}, bc_valid[c], prev_idx[c] >= 0);
            if (prev_idx[c] >= 0)
                check(bc_tag[c] == prev_tag[c], {"R9 broadcast tag ", tag}, bc_tag[c], prev_tag[c]);
        end
        @(negedge clk);
    endtask

    task automatic clear_reqs();
        req_valid = '0; req_kind = '0; req_phase = '0; req_age = '0; req_tag = '0;
    endtask

    task automatic set_req(input int i, input logic [1:0] k, input logic ph,
                           input int age, input int tg);
        req_valid[i] = 1'b1; req_kind[i] = k; req_phase[i] = ph;
        req_age[i] = AW'(age); req_tag[i] = TW'(tg);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        rst_n = 1'b0;
        clear_reqs();
        for (int i = 0; i < N; i++) set_req(i, 2'd0, 1'b0, i, i + 1);
        repeat (3) @(posedge clk);
        #1;
        // R10: broadcast stays quiet while reset is applied with live requests.
        check(bc_valid == '0, "R10 reset clears broadcast", bc_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        clear_reqs();
        step("idle");

        // R1: wrong kinds and wrong phases are never granted.
        set_req(0, 2'd2, 1'b0, 1, 10); set_req(1, 2'd3, 1'b0, 2, 11);
        set_req(2, 2'd0, 1'b1, 3, 12); set_req(3, 2'd1, 1'b0, 4, 13);
        set_req(4, 2'd2, 1'b1, 0, 14); set_req(5, 2'd3, 1'b1, 0, 15);
        step("R1 ineligible only");
        check(gnt == '0, "R1 no grant for store/branch/wrong phase", gnt, 0);

        // R3: descending ages, slots 7 and 6 are oldest.
        clear_reqs();
        for (int i = 0; i < N; i++) set_req(i, (i % 2 == 0) ? 2'd0 : 2'd1, (i % 2 == 0) ? 1'b0 : 1'b1, 40 - i, 20 + i);
        step("R3 descending ages");
        check(gnt == 8'hC0, "R3 oldest two granted", gnt, 8'hC0);
        // R7: same saturating pattern again gets the full channel count.
        step("R7 repeat saturation");
        check(free_cnt == '0 && gnt == 8'hC0, "R7 channels restored", gnt, 8'hC0);

        // R3: equal ages, lowest indices win.
        clear_reqs();
        for (int i = 0; i < N; i++) set_req(i, 2'd0, 1'b0, 9, 30 + i);
        step("R3 equal ages");
        check(gnt == 8'h03, "R3 tie-break by index", gnt, 8'h03);

        // R6/R4: a single request uses channel 0 and leaves one free.
        clear_reqs();
        set_req(5, 2'd1, 1'b1, 17, 42);
        step("R6 single request");
        check(ch_sel[0] == 8'h20 && free_cnt == CW'(1) && avail, "R6 one channel left", free_cnt, 1);

        // R8: refused request retried alone takes channel 0.
        clear_reqs();
        set_req(1, 2'd0, 1'b0, 1, 50); set_req(2, 2'd0, 1'b0, 2, 51); set_req(3, 2'd1, 1'b1, 3, 52);
        step("R8 first round");
        check(!gnt[3], "R8 youngest refused", gnt[3], 0);
        req_valid[1] = 1'b0; req_valid[2] = 1'b0;
        set_req(6, 2'd0, 1'b0, 9, 53);
        step("R8 retry");
        check(ch_sel[0] == 8'h08, "R8 retried request on channel 0", ch_sel[0], 8'h08);

        // Random traffic with mixed kinds, phases and duplicate ages.
        for (int t = 0; t < 3000; t++) begin
            int density = $urandom_range(0, 3);
            clear_reqs();
            for (int i = 0; i < N; i++) begin
                if ($urandom_range(0, 3) <= density)
                    set_req(i, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                            $urandom_range(0, 15), $urandom_range(0, 63));
            end
            step("random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule